// File: doc/BRIEF.md
# Circular Superframe Region Address Generator

This block produces the byte addresses used when slot data from a time-division serial engine is moved to and from memory. Each channel owns a circular region. Software gives the region an 8-byte-aligned base address and a length expressed in superframes. A superframe is a programmable number of 8-bit slots. Every slot byte the engine hands over moves the channel's pointer forward by one. When the final byte of the final superframe has been moved, the pointer returns to the base and a one-cycle wrap pulse is raised.

Each channel also counts completed frames and pulses a frame event once every programmed number of frames. Software uses this event to learn when a batch of frames has been stored or fetched. A frame-sync error stops the whole engine. Both pointers then hold the address at which the error was seen, until software reloads the configuration while the engine is disabled. By default there are two channels, one for received data and one for transmitted data, and each has its own slot count, length and event interval.

Top module: `cra_region_agen`

## Requirements
- R1: After reset every `next_addr` is zero, every `wrap_evt` and `frame_evt` is low, and `halted` is low.
- R2: A `load` pulse while `enable` is low stores each channel's `start_addr` with bits [2:0] cleared, sets the pointer to that base, clears the slot, frame and interval counters, and clears `halted`. The new pointer is visible in the cycle after the load edge.
- R3: A `load` pulse while `enable` is high is ignored, and the pointers and counters keep their values.
- R4: A slot byte is accepted when `byte_stb[c]` is high, `enable` is high, `halted` is low and `sync_err` is low. Each accepted byte advances `next_addr[c]` by one in the following cycle. Strobes that are not accepted change nothing.
- R5: A frame ends on the accepted byte that completes `slot_count[c]` bytes, and a `slot_count` of 0 acts as 1. On the byte that completes `region_frames[c]` frames (0 acts as 1), the pointer returns to the base instead of advancing, and `wrap_evt[c]` is high for the one following cycle.
- R6: `frame_evt[c]` is high for the one cycle after every `event_interval[c]`-th completed frame (0 acts as 1). The frame count runs on across region wraps and restarts only on a load.
- R7: When the same accepted byte both ends the region and reaches the interval, `wrap_evt[c]` and `frame_evt[c]` are high in the same cycle.
- R8: `sync_err` while `enable` is high sets `halted`, and the byte strobed in that same cycle is not accepted. While `halted` is high, every pointer holds the address at which the error was detected.
- R9: Channels are independent. Each channel's pointer and events follow only its own strobe, slot count, region length and interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Engine running |
| sync_err | input | 1 | Frame-sync error detected (halts engine) |
| load | input | 1 | Capture bases and restart counters (only while disabled) |
| start_addr | input | NCH x ADDR_W | Per-channel region base; low 3 bits ignored |
| slot_count | input | NCH x SLOT_W | Slots per superframe per channel |
| region_frames | input | NCH x LEN_W | Region length in superframes per channel |
| event_interval | input | NCH x IVL_W | Frames between frame events per channel |
| byte_stb | input | NCH | One slot byte moved on that channel |
| next_addr | output | NCH x ADDR_W | Address of the next byte per channel |
| wrap_evt | output | NCH | Region wrapped (one-cycle pulse) |
| frame_evt | output | NCH | Interval of frames completed (one-cycle pulse) |
| halted | output | 1 | Engine stopped by a frame-sync error |

## Verification
The wrap pulse and the frame-interval pulse come from separate counters, and the two can fire on the same accepted byte. The bench provokes this with a sweep over every small slot count, region length and interval, including zero, on both channels together. Where the interval divides the region's frame count, the final byte of each pass raises both pulses at once. Each pulse is judged against arithmetic on the number of bytes accepted since the last load: the byte count modulo slots times frames for the wrap, and the frame number modulo the interval for the frame event. The bench also confirms that at least one such coincidence occurred.

// File: rtl/cra_pkg.sv
package cra_pkg;

   // event pair produced by one channel pointer
   typedef struct packed {
      logic wrap;
      logic frame;
   } cra_evt_t;

   // alignment of a region base in address bits
   localparam int CRA_ALIGN_BITS = 3;

endpackage

// File: rtl/cra_frame_track.sv
module cra_frame_track #(
   parameter int SLOT_W = 10,
   parameter int LEN_W  = 16,
   parameter int IVL_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              adv,
   input  logic [SLOT_W-1:0] slots,
   input  logic [LEN_W-1:0]  frames,
   input  logic [IVL_W-1:0]  ivl,
   output logic              region_end,
   output logic              ivl_hit
);
   localparam int SW1 = SLOT_W + 1;
   localparam int LW1 = LEN_W + 1;
   localparam int IW1 = IVL_W + 1;

   logic [SLOT_W-1:0] slot_idx;
   logic [LEN_W-1:0]  frame_idx;
   logic [IVL_W-1:0]  ivl_cnt;
   logic              last_slot;

   // a programmed zero behaves like one: index+1 >= 0 always holds
   always_comb begin
      last_slot  = ({1'b0, slot_idx} + SW1'(1)) >= {1'b0, slots};
      region_end = last_slot && (({1'b0, frame_idx} + LW1'(1)) >= {1'b0, frames});
      ivl_hit    = last_slot && (({1'b0, ivl_cnt} + IW1'(1)) >= {1'b0, ivl});
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         slot_idx  <= '0;
         frame_idx <= '0;
         ivl_cnt   <= '0;
      end else if (adv) begin
         if (last_slot) begin
            slot_idx  <= '0;
            frame_idx <= region_end ? '0 : frame_idx + LEN_W'(1);
            ivl_cnt   <= ivl_hit ? '0 : ivl_cnt + IVL_W'(1);
         end else begin
            slot_idx  <= slot_idx + SLOT_W'(1);
         end
      end
   end

   // R5
   slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && last_slot && !clear) |=> (slot_idx == '0));

endmodule

// File: rtl/cra_ptr.sv
module cra_ptr
   import cra_pkg::*;
#(
   parameter int ADDR_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] start_in,
   input  logic              adv,
   input  logic              region_end,
   input  logic              ivl_hit,
   output logic [ADDR_W-1:0] ptr,
   output cra_evt_t          evt
);
   localparam logic [ADDR_W-1:0] BASE_MASK =
      {{(ADDR_W-CRA_ALIGN_BITS){1'b1}}, {CRA_ALIGN_BITS{1'b0}}};

   generate
      if (ADDR_W <= CRA_ALIGN_BITS) begin : g_bad_width
         $error("cra_ptr: ADDR_W must exceed the alignment bits");
      end
   endgenerate

   logic [ADDR_W-1:0] start_q;
   logic [ADDR_W-1:0] ptr_q;
   cra_evt_t          evt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         ptr_q   <= '0;
         evt_q   <= '0;
      end else if (load) begin
         start_q <= start_in & BASE_MASK;
         ptr_q   <= start_in & BASE_MASK;
         evt_q   <= '0;
      end else begin
         evt_q.wrap  <= adv && region_end;
         evt_q.frame <= adv && ivl_hit;
         if (adv) ptr_q <= region_end ? start_q : ptr_q + ADDR_W'(1);
      end
   end

   assign ptr = ptr_q;
   assign evt = evt_q;

   // R4
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !region_end && !load) |=> (ptr_q == $past(ptr_q) + ADDR_W'(1)));

   // R5
   wrap_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q.wrap |-> (ptr_q == start_q));

   // R6
   frame_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q.frame |-> $past(adv));

   // R2
   load_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (ptr_q[CRA_ALIGN_BITS-1:0] == '0 && !evt_q.wrap && !evt_q.frame));

endmodule

// File: rtl/cra_region_agen.sv
module cra_region_agen
   import cra_pkg::*;
#(
   parameter int NCH    = 2,
   parameter int ADDR_W = 36,
   parameter int SLOT_W = 10,
   parameter int LEN_W  = 16,
   parameter int IVL_W  = 10
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         enable,
   input  logic                         sync_err,
   input  logic                         load,
   input  logic [NCH-1:0][ADDR_W-1:0]   start_addr,
   input  logic [NCH-1:0][SLOT_W-1:0]   slot_count,
   input  logic [NCH-1:0][LEN_W-1:0]    region_frames,
   input  logic [NCH-1:0][IVL_W-1:0]    event_interval,
   input  logic [NCH-1:0]               byte_stb,
   output logic [NCH-1:0][ADDR_W-1:0]   next_addr,
   output logic [NCH-1:0]               wrap_evt,
   output logic [NCH-1:0]               frame_evt,
   output logic                         halted
);
   generate
      if (NCH < 1) begin : g_bad_nch
         $error("cra_region_agen: NCH must be at least 1");
      end
      if (SLOT_W < 1 || LEN_W < 1 || IVL_W < 1) begin : g_bad_cnt
         $error("cra_region_agen: counter widths must be positive");
      end
   endgenerate

   logic           halted_q;
   logic           load_ok;
   logic           active;
   logic [NCH-1:0] adv;
   logic [NCH-1:0] reg_end;
   logic [NCH-1:0] ivl_hit;
   cra_evt_t       evt [NCH];

   assign load_ok = load && !enable;
   assign active  = enable && !halted_q && !sync_err;
   assign adv     = byte_stb & {NCH{active}};

   always_ff @(posedge clk) begin
      if (!rst_n)                 halted_q <= 1'b0;
      else if (load_ok)           halted_q <= 1'b0;
      else if (enable && sync_err) halted_q <= 1'b1;
   end

   assign halted = halted_q;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      cra_frame_track #(.SLOT_W(SLOT_W), .LEN_W(LEN_W), .IVL_W(IVL_W)) u_trk (
         .clk        (clk),
         .rst_n      (rst_n),
         .clear      (load_ok),
         .adv        (adv[c]),
         .slots      (slot_count[c]),
         .frames     (region_frames[c]),
         .ivl        (event_interval[c]),
         .region_end (reg_end[c]),
         .ivl_hit    (ivl_hit[c])
      );
      cra_ptr #(.ADDR_W(ADDR_W)) u_ptr (
         .clk        (clk),
         .rst_n      (rst_n),
         .load       (load_ok),
         .start_in   (start_addr[c]),
         .adv        (adv[c]),
         .region_end (reg_end[c]),
         .ivl_hit    (ivl_hit[c]),
         .ptr        (next_addr[c]),
         .evt        (evt[c])
      );
      assign wrap_evt[c]  = evt[c].wrap;
      assign frame_evt[c] = evt[c].frame;
   end

   // R8
   halt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && sync_err) |=> halted_q);

   // R8
   halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halted_q && !load_ok) |=> $stable(next_addr));

   // R3
   load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && enable && byte_stb == '0) |=> $stable(next_addr));

endmodule

// File: tb/sim_cra_region_agen.sv
module sim_cra_region_agen;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 12;
   localparam int SW = 3;
   localparam int LW = 3;
   localparam int IW = 3;

   logic                 clk;
   logic                 rst_n;
   logic                 enable;
   logic                 sync_err;
   logic                 load;
   logic [1:0][AW-1:0]   start_addr;
   logic [1:0][SW-1:0]   slot_count;
   logic [1:0][LW-1:0]   region_frames;
   logic [1:0][IW-1:0]   event_interval;
   logic [1:0]           byte_stb;
   logic [1:0][AW-1:0]   next_addr;
   logic [1:0]           wrap_evt;
   logic [1:0]           frame_evt;
   logic                 halted;

   cra_region_agen #(.NCH(2), .ADDR_W(AW), .SLOT_W(SW), .LEN_W(LW), .IVL_W(IW)) u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .sync_err(sync_err), .load(load),
      .start_addr(start_addr), .slot_count(slot_count), .region_frames(region_frames),
      .event_interval(event_interval), .byte_stb(byte_stb), .next_addr(next_addr),
      .wrap_evt(wrap_evt), .frame_evt(frame_evt), .halted(halted)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int fails = 0;
   int coincide = 0;
   int n [2];
   int sv [2];
   int lv [2];
   int iv [2];
   int base [2];

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int eff(int v);
      return (v == 0) ? 1 : v;
   endfunction

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // expected outputs of channel c after one clock, acc = byte accepted at that edge
   task automatic expect_ch(int c, bit acc, string tag);
      int s = eff(sv[c]);
      int l = eff(lv[c]);
      int i = eff(iv[c]);
      bit w = 1'b0;
      bit f = 1'b0;
      string ct = (c == 1) ? " R9 ch1" : " ch0";
      if (acc) begin
         n[c]++;
         w = (n[c] % (s * l)) == 0;
         f = ((n[c] % s) == 0) && (((n[c] / s) % i) == 0);
      end
      chk({tag, ct, " R4 addr"}, int'(next_addr[c]), base[c] + (n[c] % (s * l)));
      chk({tag, ct, " R5 wrap"}, int'(wrap_evt[c]), int'(w));
      chk({tag, ct, " R6 frame"}, int'(frame_evt[c]), int'(f));
      if (acc && w && f && wrap_evt[c] && frame_evt[c]) coincide++;
   endtask

   task automatic load_cfg(int k);
      enable = 1'b0;
      byte_stb = 2'b00;
      load = 1'b1;
      for (int c = 0; c < 2; c++) begin
         int raw = (c == 0 ? 'h400 : 'h800) + k * 8 + ((k + 3 * c) % 8);
         start_addr[c]     = AW'(raw);
         slot_count[c]     = SW'(sv[c]);
         region_frames[c]  = LW'(lv[c]);
         event_interval[c] = IW'(iv[c]);
         base[c] = raw & ~7;
         n[c] = 0;
      end
      tick();
      load = 1'b0;
      expect_ch(0, 1'b0, "R2 load");
      expect_ch(1, 1'b0, "R2 load");
      chk("R2 halted cleared", int'(halted), 0);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      enable = 1'b0;
      sync_err = 1'b0;
      load = 1'b0;
      start_addr = '0;
      slot_count = '0;
      region_frames = '0;
      event_interval = '0;
      byte_stb = 2'b00;
      repeat (3) tick();
      // R1 reset state
      chk("R1 addr0", int'(next_addr[0]), 0);
      chk("R1 addr1", int'(next_addr[1]), 0);
      chk("R1 wrap", int'(wrap_evt), 0);
      chk("R1 frame", int'(frame_evt), 0);
      chk("R1 halted", int'(halted), 0);
      rst_n = 1'b1;
      tick();

      // sweep all small settings, including zero, on both channels at once
      for (int s = 0; s <= 4; s++) begin
         for (int l = 0; l <= 3; l++) begin
            for (int i = 0; i <= 3; i++) begin
               int k = s * 16 + l * 4 + i;
               int steps;
               sv[0] = s;     lv[0] = l;     iv[0] = i;
               sv[1] = 4 - s; lv[1] = 3 - l; iv[1] = (i + 1) % 4;
               load_cfg(k);
               enable = 1'b1;
               steps = 2 * eff(s) * eff(l) + 3;
               for (int t = 0; t < steps; t++) begin
                  bit a0 = (t % 5) != 4;
                  bit a1 = (t % 2) == 0;
                  byte_stb = {a1, a0};
                  tick();
                  expect_ch(0, a0, "R7 sweep");
                  expect_ch(1, a1, "R7 sweep");
               end
               byte_stb = 2'b00;
               enable = 1'b0;
            end
         end
      end
      chk("R7 coincident wrap and frame seen", int'(coincide > 0), 1);

      // R3: load while enabled is ignored
      sv[0] = 2; lv[0] = 2; iv[0] = 1;
      sv[1] = 3; lv[1] = 1; iv[1] = 2;
      load_cfg(5);
      enable = 1'b1;
      byte_stb = 2'b11;
      tick();
      expect_ch(0, 1'b1, "R4 run");
      expect_ch(1, 1'b1, "R4 run");
      byte_stb = 2'b00;
      load = 1'b1;
      start_addr[0] = AW'('hF00);
      start_addr[1] = AW'('hE00);
      tick();
      load = 1'b0;
      expect_ch(0, 1'b0, "R3 load ignored");
      expect_ch(1, 1'b0, "R3 load ignored");

      // R4: strobes while disabled are ignored
      enable = 1'b0;
      byte_stb = 2'b11;
      tick();
      expect_ch(0, 1'b0, "R4 disabled");
      expect_ch(1, 1'b0, "R4 disabled");

      // R8: error freezes pointers, same-cycle byte dropped
      enable = 1'b1;
      tick();
      expect_ch(0, 1'b1, "R8 pre");
      expect_ch(1, 1'b1, "R8 pre");
      sync_err = 1'b1;
      tick();
      sync_err = 1'b0;
      chk("R8 halted set", int'(halted), 1);
      expect_ch(0, 1'b0, "R8 err cycle");
      expect_ch(1, 1'b0, "R8 err cycle");
      for (int t = 0; t < 3; t++) begin
         tick();
         chk("R8 still halted", int'(halted), 1);
         expect_ch(0, 1'b0, "R8 frozen");
         expect_ch(1, 1'b0, "R8 frozen");
      end

      // R2: reload while disabled clears halt and restarts counting
      load_cfg(9);
      enable = 1'b1;
      byte_stb = 2'b11;
      for (int t = 0; t < 7; t++) begin
         tick();
         expect_ch(0, 1'b1, "R2 restart");
         expect_ch(1, 1'b1, "R2 restart");
      end
      byte_stb = 2'b00;
      enable = 1'b0;
      tick();

      summary();
      $finish;
   end
endmodule